// File: doc/BRIEF.md
# Opcode-Gated Multi-Unit ALU

This block is one execute stage holding five functional units: an adder, a logic unit, a shifter, a comparator and a multiplier. Each unit has its own pair of operand registers. The opcode class arrives one cycle ahead of its operands. A small gating controller turns that early opcode into a registered one-hot load enable. When the operands arrive, only the selected unit's registers take them. Every other unit's registers stay quiet, so that unit's logic sees no input activity. The load enables stand in for clock-gate cells.

A static configuration input picks what an idle unit does. In hold mode it keeps its last operands. In standby mode it parks its registers on a fixed pattern that minimises leakage. The result of the selected unit is registered and forwarded alone. For observation there is a per-unit count of cycles in which that unit's operand registers changed.

The gating controller has two states. GS_IDLE means no unit is armed, so all enables are low. GS_ARMED means one unit is armed, and exactly one enable is high. At each clock edge, a valid early opcode with a legal class moves the controller to GS_ARMED (from either state) and records the class. Anything else returns it to GS_IDLE. An operation may be issued every cycle.

Top module: `opgate_alu`

## Requirements
- R1: The cycle after `pre_valid_i` is sampled high with `pre_op_i` in 0..4, `unit_en_o` is one-hot, with bit `pre_op_i` set. The class codes are 0 adder, 1 logic (XOR), 2 shifter, 3 comparator and 4 multiplier.
- R2: If `pre_valid_i` is low or `pre_op_i` is 5, 6 or 7 at an edge, then in the next cycle `unit_en_o` is zero, and that request produces no `result_valid_o` pulse and no change of `result_o`.
- R3: A unit whose enable is high captures `opa_i` and `opb_i` at the closing edge of that cycle. That cycle is the one following the opcode.
- R4: With `standby_mode_i` low, a unit whose enable is low keeps both operand registers unchanged, and its toggle count does not advance.
- R5: With `standby_mode_i` high, a unit whose enable is low loads its standby pattern into both operand registers. The pattern is all ones for units 0, 2 and 4, and all zeros for units 1 and 3.
- R6: For a legal request, `result_o` and a one-cycle `result_valid_o` pulse appear two edges after the edge that sampled the opcode. `result_o` holds its value at all other times.
- R7: The unit results, all modulo 2^WIDTH, are: a+b; a XOR b; a shifted left by the low log2(WIDTH) bits of b; 1 if a<b unsigned, else 0; the low WIDTH bits of a*b.
- R8: Unit k's count at `toggle_cnt_o[k*CNT_W +: CNT_W]` advances by one at every edge where either of its operand registers changes value, and wraps at 2^CNT_W.
- R9: After reset, `unit_en_o`, `result_o`, `result_valid_o`, all operand registers and all counts are zero.
- R10: Requests may be issued on consecutive cycles. Each one yields its own result in issue order, one cycle apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_mode_i | input | 1 | Static: 1 parks idle units on the standby pattern, 0 holds their operands |
| pre_valid_i | input | 1 | Early request valid |
| pre_op_i | input | 3 | Early opcode class, one cycle ahead of the operands |
| opa_i | input | WIDTH | Operand A, presented the cycle after the opcode |
| opb_i | input | WIDTH | Operand B, presented the cycle after the opcode |
| unit_en_o | output | 5 | Per-unit load enable (gating signal) |
| result_o | output | WIDTH | Registered result of the selected unit |
| result_valid_o | output | 1 | One-cycle pulse when `result_o` is new |
| toggle_cnt_o | output | 5*CNT_W | Per-unit operand-change counts, unit k in slice k |

## Verification
The enable for a request is due one edge after the opcode is sampled. The operands are captured at the second edge. The result, its valid pulse and the updated toggle counts are due right after the third edge of the request's window.

The bench drives inputs and samples outputs on falling edges. It checks the enables in the falling edge after the opcode edge, and the result and counts in the falling edge after the capture edge's successor.

A bench-side model of every unit's operand registers is stepped once per rising edge, using the enable that the requirements call for. The expected counts therefore follow edge by edge, in both hold and standby mode.

// File: rtl/opgate_pkg.sv
package opgate_pkg;

    localparam int NUM_UNITS = 5;
    localparam int OP_W      = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 3'd0,
        OP_LOGIC = 3'd1,
        OP_SHIFT = 3'd2,
        OP_CMP   = 3'd3,
        OP_MUL   = 3'd4
    } op_class_e;

    typedef enum logic {
        GS_IDLE  = 1'b0,
        GS_ARMED = 1'b1
    } gate_state_e;

    function automatic logic op_is_legal(input logic [OP_W-1:0] op);
        return op < 3'(NUM_UNITS);
    endfunction

endpackage

// File: rtl/opgate_ctrl.sv
module opgate_ctrl
    import opgate_pkg::*;
#(
    parameter int NU = NUM_UNITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_valid_i,
    input  logic [OP_W-1:0]   pre_op_i,
    output logic [NU-1:0]     unit_en_o,
    output logic [OP_W-1:0]   sel_o
);

    localparam logic [NU-1:0] ONE_HOT_BASE = {{(NU-1){1'b0}}, 1'b1};

    gate_state_e           state_q;
    logic [OP_W-1:0]       armed_q;
    logic                  arm_req;

    assign arm_req = pre_valid_i && op_is_legal(pre_op_i);

    // State register: decision is taken one cycle before operand capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            armed_q <= '0;
        end else begin
            unique case (state_q)
                GS_IDLE: begin
                    if (arm_req) begin
                        state_q <= GS_ARMED;
                        armed_q <= pre_op_i;
                    end
                end
                GS_ARMED: begin
                    if (arm_req) begin
                        armed_q <= pre_op_i;
                    end else begin
                        state_q <= GS_IDLE;
                    end
                end
                default: state_q <= GS_IDLE;
            endcase
        end
    end

    // Output process: enables derived from state only.
    always_comb begin
        unit_en_o = '0;
        unique case (state_q)
            GS_IDLE:  unit_en_o = '0;
            GS_ARMED: unit_en_o = ONE_HOT_BASE << armed_q;
            default:  unit_en_o = '0;
        endcase
    end

    assign sel_o = armed_q;

    p_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_valid_i && (pre_op_i < 3'(NU))) |=>
            ($onehot(unit_en_o) && (sel_o == $past(pre_op_i))));

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_valid_i && (pre_op_i < 3'(NU))) |=> (unit_en_o == '0));

endmodule

// File: rtl/opgate_unit.sv
module opgate_unit #(
    parameter int W    = 16,
    parameter int CW   = 16,
    parameter int KIND = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          standby_i,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    output logic [W-1:0]  y_o,
    output logic [CW-1:0] cnt_o
);

    localparam int SHW = (W > 1) ? $clog2(W) : 1;
    localparam logic [W-1:0] STBY_PAT = (KIND % 2 == 0) ? {W{1'b1}} : {W{1'b0}};

    logic [W-1:0]  a_q, b_q, a_d, b_d;
    logic [CW-1:0] cnt_q;
    logic          upd;
    logic          chg;

    always_comb begin
        a_d = a_q;
        b_d = b_q;
        if (load_i) begin
            a_d = opa_i;
            b_d = opb_i;
        end else if (standby_i) begin
            a_d = STBY_PAT;
            b_d = STBY_PAT;
        end
    end

    // The register only opens when loading or parking: the gated-clock model.
    assign upd = load_i || standby_i;
    assign chg = (a_d != a_q) || (b_d != b_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            cnt_q <= '0;
        end else begin
            if (upd) begin
                a_q <= a_d;
                b_q <= b_d;
            end
            if (upd && chg) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;

    generate
        if (KIND == 0) begin : g_add
            assign y_o = a_q + b_q;
        end else if (KIND == 1) begin : g_logic
            assign y_o = a_q ^ b_q;
        end else if (KIND == 2) begin : g_shift
            assign y_o = a_q << b_q[SHW-1:0];
        end else if (KIND == 3) begin : g_cmp
            assign y_o = {{(W-1){1'b0}}, (a_q < b_q)};
        end else begin : g_mul
            assign y_o = a_q * b_q;
        end
    endgenerate

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ((a_q == $past(opa_i)) && (b_q == $past(opb_i))));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !standby_i) |=> ($stable(a_q) && $stable(b_q) && $stable(cnt_q)));

    p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && standby_i) |=> ((a_q == STBY_PAT) && (b_q == STBY_PAT)));

    p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(a_q) && $stable(b_q)) |-> $stable(cnt_q));

endmodule

// File: rtl/opgate_alu.sv
module opgate_alu
    import opgate_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        standby_mode_i,
    input  logic                        pre_valid_i,
    input  logic [OP_W-1:0]             pre_op_i,
    input  logic [WIDTH-1:0]            opa_i,
    input  logic [WIDTH-1:0]            opb_i,
    output logic [NUM_UNITS-1:0]        unit_en_o,
    output logic [WIDTH-1:0]            result_o,
    output logic                        result_valid_o,
    output logic [NUM_UNITS*CNT_W-1:0]  toggle_cnt_o
);

    localparam int NU = NUM_UNITS;

    logic [NU-1:0]     en;
    logic [OP_W-1:0]   sel;
    logic [WIDTH-1:0]  unit_y [NU];
    logic [CNT_W-1:0]  unit_cnt [NU];
    logic              cap_vld_q;
    logic [OP_W-1:0]   cap_op_q;
    logic [WIDTH-1:0]  sel_y;
    logic [WIDTH-1:0]  res_q;
    logic              res_vld_q;

    opgate_ctrl #(.NU(NU)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pre_valid_i (pre_valid_i),
        .pre_op_i    (pre_op_i),
        .unit_en_o   (en),
        .sel_o       (sel)
    );

    generate
        for (genvar k = 0; k < NU; k++) begin : g_unit
            opgate_unit #(.W(WIDTH), .CW(CNT_W), .KIND(k)) u_unit (
                .clk       (clk),
                .rst_n     (rst_n),
                .load_i    (en[k]),
                .standby_i (standby_mode_i),
                .opa_i     (opa_i),
                .opb_i     (opb_i),
                .y_o       (unit_y[k]),
                .cnt_o     (unit_cnt[k])
            );
            assign toggle_cnt_o[k*CNT_W +: CNT_W] = unit_cnt[k];
        end
    endgenerate

    // Capture stage: remembers which unit took operands this edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vld_q <= 1'b0;
            cap_op_q  <= '0;
        end else begin
            cap_vld_q <= |en;
            if (|en) begin
                cap_op_q <= sel;
            end
        end
    end

    always_comb begin
        sel_y = '0;
        for (int k = 0; k < NU; k++) begin
            if (cap_op_q == 3'(k)) begin
                sel_y = unit_y[k];
            end
        end
    end

    // Result stage: sampled before an idle unit parks on its standby pattern.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_vld_q <= 1'b0;
        end else begin
            res_vld_q <= cap_vld_q;
            if (cap_vld_q) begin
                res_q <= sel_y;
            end
        end
    end

    assign unit_en_o      = en;
    assign result_o       = res_q;
    assign result_valid_o = res_vld_q;

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_en_o));

    p_hold_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid_o |-> $stable(result_o));

    p_valid_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_en_o) |=> ##1 result_valid_o);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en_o == '0) |=> ##1 !result_valid_o);

endmodule

// File: tb/opgate_alu_bench.sv
module opgate_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int CW = 8;
    localparam int NU = 5;
    localparam int WATCHDOG = 100000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                standby_mode_i = 1'b0;
    logic                pre_valid_i = 1'b0;
    logic [2:0]          pre_op_i = '0;
    logic [W-1:0]        opa_i = '0;
    logic [W-1:0]        opb_i = '0;
    logic [NU-1:0]       unit_en_o;
    logic [W-1:0]        result_o;
    logic                result_valid_o;
    logic [NU*CW-1:0]    toggle_cnt_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    int m_a [NU];
    int m_b [NU];
    int m_cnt [NU];
    int last_res = 0;

    opgate_alu #(.WIDTH(W), .CNT_W(CW)) u_opgate_alu (
        .clk            (clk),
        .rst_n          (rst_n),
        .standby_mode_i (standby_mode_i),
        .pre_valid_i    (pre_valid_i),
        .pre_op_i       (pre_op_i),
        .opa_i          (opa_i),
        .opb_i          (opb_i),
        .unit_en_o      (unit_en_o),
        .result_o       (result_o),
        .result_valid_o (result_valid_o),
        .toggle_cnt_o   (toggle_cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog: actual cycles=%0d expected <= %0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int stby_pat(input int k);
        return (k % 2 == 0) ? ((1 << W) - 1) : 0;
    endfunction

    function automatic int expect_res(input int op, input int a, input int b);
        int mask = (1 << W) - 1;
        case (op)
            0: return (a + b) & mask;
            1: return a ^ b;
            2: return (a << (b % W)) & mask;
            3: return (a < b) ? 1 : 0;
            default: return (a * b) & mask;
        endcase
    endfunction

    // Steps the register model across one rising edge; en_idx < 0 means no unit enabled.
    task automatic model_edge(input int en_idx, input int a, input int b);
        for (int k = 0; k < NU; k++) begin
            int na = m_a[k];
            int nb = m_b[k];
            if (k == en_idx) begin
                na = a;
                nb = b;
            end else if (standby_mode_i) begin
                na = stby_pat(k);
                nb = stby_pat(k);
            end
            if (na != m_a[k] || nb != m_b[k]) m_cnt[k]++;
            m_a[k] = na;
            m_b[k] = nb;
        end
    endtask

    task automatic check_counts(input string req);
        for (int k = 0; k < NU; k++) begin
            int act = int'(toggle_cnt_o[k*CW +: CW]);
            int exp = m_cnt[k] % (1 << CW);
            chk(act == exp, req, act, exp);
        end
    endtask

    task automatic run_op(input bit vld, input int op, input int a, input int b);
        bit legal = vld && (op < NU);
        @(negedge clk);
        pre_valid_i = vld;
        pre_op_i = 3'(op);
        @(posedge clk);
        model_edge(-1, 0, 0);
        @(negedge clk);
        if (legal)
            chk(unit_en_o == NU'(1 << op), "R1 enable one-hot", int'(unit_en_o), 1 << op);
        else
            chk(unit_en_o == '0, "R2 no enable", int'(unit_en_o), 0);
        pre_valid_i = 1'b0;
        opa_i = W'(a);
        opb_i = W'(b);
        @(posedge clk);
        model_edge(legal ? op : -1, a, b);
        @(posedge clk);
        model_edge(-1, 0, 0);
        @(negedge clk);
        if (legal) begin
            last_res = expect_res(op, a, b);
            chk(result_valid_o == 1'b1, "R6 valid pulse", int'(result_valid_o), 1);
            chk(int'(result_o) == last_res, "R7 result", int'(result_o), last_res);
        end else begin
            chk(result_valid_o == 1'b0, "R2 no valid", int'(result_valid_o), 0);
            chk(int'(result_o) == last_res, "R2 result held", int'(result_o), last_res);
        end
        check_counts(standby_mode_i ? "R5 R8 counts" : "R4 R8 counts");
    endtask

    initial begin
        for (int k = 0; k < NU; k++) begin
            m_a[k] = 0;
            m_b[k] = 0;
            m_cnt[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(unit_en_o == '0, "R9 enables", int'(unit_en_o), 0);
        chk(result_o == '0, "R9 result", int'(result_o), 0);
        chk(result_valid_o == 1'b0, "R9 valid", int'(result_valid_o), 0);
        chk(toggle_cnt_o == '0, "R9 counts", int'(toggle_cnt_o), 0);

        // R1 R3 R4 R7 R8: exhaustive sweep in hold mode, including illegal classes (R2)
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < (1 << W); a++)
                for (int b = 0; b < (1 << W); b++)
                    run_op(1'b1, op, a, b);

        // R2: legal class with the valid bit low
        for (int op = 0; op < NU; op++) run_op(1'b0, op, 9, 6);

        // R5: standby mode, idle units park on their pattern
        @(negedge clk);
        standby_mode_i = 1'b1;
        for (int op = 0; op < NU; op++)
            for (int a = 0; a < (1 << W); a++)
                for (int b = 0; b < (1 << W); b += 5)
                    run_op(1'b1, op, a, b);
        run_op(1'b1, 6, 3, 3);
        @(negedge clk);
        standby_mode_i = 1'b0;

        // R10: back-to-back requests, add 3+4 then multiply 5*3
        @(negedge clk);
        pre_valid_i = 1'b1;
        pre_op_i = 3'd0;
        @(posedge clk);
        model_edge(-1, 0, 0);
        @(negedge clk);
        chk(unit_en_o == 5'b00001, "R10 first enable", int'(unit_en_o), 1);
        opa_i = 4'd3;
        opb_i = 4'd4;
        pre_op_i = 3'd4;
        @(posedge clk);
        model_edge(0, 3, 4);
        @(negedge clk);
        chk(unit_en_o == 5'b10000, "R10 second enable", int'(unit_en_o), 16);
        pre_valid_i = 1'b0;
        opa_i = 4'd5;
        opb_i = 4'd3;
        @(posedge clk);
        model_edge(4, 5, 3);
        @(negedge clk);
        chk(result_valid_o && result_o == 4'd7, "R10 first result", int'(result_o), 7);
        @(posedge clk);
        model_edge(-1, 0, 0);
        @(negedge clk);
        chk(result_valid_o && result_o == 4'd15, "R10 second result", int'(result_o), 15);
        @(posedge clk);
        model_edge(-1, 0, 0);
        @(negedge clk);
        chk(result_valid_o == 1'b0, "R6 pulse ends", int'(result_valid_o), 0);
        chk(result_o == 4'd15, "R6 result held", int'(result_o), 15);
        check_counts("R8 counts after burst");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule